// File: doc/BRIEF.md
# Pipeline Load-Use Stall and Branch Flush Sequencer

This block sequences a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) that runs four kinds of instruction: word load, word store, register add/subtract, and branch-if-equal. It keeps a record for each stage: a valid flag, the instruction class, three register/offset fields and the instruction index. From these records it decides when the decode stage must wait on a load, and when a taken branch must discard the younger work. It also produces the control word for each instruction and carries the parts each later stage needs.

The surrounding datapath supplies the fields of the instruction at the current fetch index and a branch-taken flag for the branch in execute. It receives the fetch index back. Operand values, the register file and data memory live elsewhere. Every dependence other than those listed below is assumed to be resolved by forwarding.

Top module: `loaduse_ctrl`

## Requirements
- R1: After reset the fetch index is 0, every stage is empty, all control words are zero, and stall and flush are low.
- R2: An add/sub (class 2; destination field A, sources fields B and C) in decode stalls for one cycle when a valid load (class 0, destination field A) in execute writes field B or field C.
- R3: A store (class 1; data register field A, base register field B) in decode stalls only when a load in execute writes field A. A match on field B alone causes no stall.
- R4: A branch (class 3; compares fields A and B) in decode stalls when a load in execute or a load in memory writes either compared register, so a branch right behind a load stalls for two consecutive cycles.
- R5: In a stall cycle the fetch index and the decode record hold, execute receives an empty record, and the memory and writeback stages advance.
- R6: The 7-bit execute control word is {RegDst, ALUSrc, Branch, MemRead, MemWrite, RegWrite, MemToReg} (bit 6 down to 0): load 0101011, store 0100100, add/sub 1000010, branch 0010000. Don't-care bits are 0, and an empty stage carries 0.
- R7: The memory stage carries bits 4..0 of an instruction's execute word, and the writeback stage carries bits 1..0.
- R8: When branch-taken is high and execute holds a valid branch, flush is high. On the next cycle decode and execute are empty and the fetch index is the branch's index plus its sign-extended 6-bit offset (field) plus one.
- R9: When a flush and a stall condition arise in the same cycle, flush is high and stall is low.
- R10: Register 0 never causes a stall. A load or add/sub whose destination is register 0 has RegWrite (bit 1) cleared.
- R11: An add/sub or store whose matching load has already reached the memory stage, and a load whose base register matches a load in execute, do not stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetchValid | input | 1 | An instruction exists at the fetch index |
| fetchClass | input | 2 | Class of the fetched instruction (0 load, 1 store, 2 add/sub, 3 branch) |
| fetchRegA | input | 5 | Register field A |
| fetchRegB | input | 5 | Register field B |
| fetchRegC | input | 5 | Register field C |
| fetchOffset | input | 6 | Signed branch offset |
| branchTaken | input | 1 | Compare result for the branch in execute |
| fetchPc | output | 8 | Current fetch index |
| stall | output | 1 | Decode is held and execute gets a bubble |
| flush | output | 1 | Taken branch discards decode and fetch |
| idValid | output | 1 | Decode stage occupied |
| idClass | output | 2 | Decode stage class |
| exValid | output | 1 | Execute stage occupied |
| exClass | output | 2 | Execute stage class |
| memValid | output | 1 | Memory stage occupied |
| memClass | output | 2 | Memory stage class |
| wbValid | output | 1 | Writeback stage occupied |
| wbClass | output | 2 | Writeback stage class |
| exCtrl | output | 7 | Execute control word |
| memCtrl | output | 5 | Memory control word |
| wbCtrl | output | 2 | Writeback control word |

## Verification
A hold request and a redirect can land in the same cycle. This happens when a branch sits in decode waiting on a load that has reached the memory stage while the branch ahead of it, now in execute, is taken. The bench builds exactly that three-instruction sequence. It requires flush high with stall low in that cycle, and the fetch index at the redirect target one cycle later rather than held. A cycle-accurate reference model in the bench checks stage occupancy, control words and both strobes every cycle, including the cycles around the collision.

// File: rtl/pipe_pkg.sv
package pipe_pkg;
  localparam int REG_W  = 5;
  localparam int PC_W   = 8;
  localparam int OFF_W  = 6;
  localparam int CW_EX  = 7;
  localparam int CW_MEM = 5;
  localparam int CW_WB  = 2;

  typedef enum logic [1:0] {
    CL_LOAD  = 2'd0,
    CL_STORE = 2'd1,
    CL_ALU   = 2'd2,
    CL_BEQ   = 2'd3
  } instClass_t;

  typedef struct packed {
    logic             valid;
    instClass_t       cls;
    logic [REG_W-1:0] regA;
    logic [REG_W-1:0] regB;
    logic [REG_W-1:0] regC;
    logic [OFF_W-1:0] offset;
    logic [PC_W-1:0]  pc;
  } stage_t;

  // strobes from the hazard control to the stage registers
  typedef struct packed {
    logic holdFront;
    logic bubbleEx;
    logic squash;
  } strobe_t;

  // {RegDst, ALUSrc, Branch, MemRead, MemWrite, RegWrite, MemToReg}
  function automatic logic [CW_EX-1:0] ctrlWord(instClass_t c, logic [REG_W-1:0] dst);
    logic [CW_EX-1:0] w;
    case (c)
      CL_LOAD:  w = 7'b01_010_11;
      CL_STORE: w = 7'b01_001_00;
      CL_ALU:   w = 7'b10_000_10;
      default:  w = 7'b00_100_00;
    endcase
    if ((c == CL_LOAD || c == CL_ALU) && dst == '0) w[1] = 1'b0;
    return w;
  endfunction
endpackage

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import pipe_pkg::*;
(
  input  stage_t  idStage,
  input  stage_t  exStage,
  input  stage_t  memStage,
  input  logic    branchTaken,
  input  logic    clk,
  input  logic    rst_n,
  output strobe_t strobe,
  output logic    stall,
  output logic    flush
);
  function automatic logic loadWrites(stage_t s, logic [REG_W-1:0] r);
    return s.valid && s.cls == CL_LOAD && s.regA != '0 && s.regA == r;
  endfunction

  logic needWait;
  logic unusedFields;
  assign unusedFields = ^{idStage, exStage, memStage};

  always_comb begin
    needWait = 1'b0;
    if (idStage.valid) begin
      case (idStage.cls)
        CL_ALU:   needWait = loadWrites(exStage, idStage.regB) ||
                             loadWrites(exStage, idStage.regC);
        CL_STORE: needWait = loadWrites(exStage, idStage.regA);
        CL_BEQ:   needWait = loadWrites(exStage, idStage.regA) ||
                             loadWrites(exStage, idStage.regB) ||
                             loadWrites(memStage, idStage.regA) ||
                             loadWrites(memStage, idStage.regB);
        default:  needWait = 1'b0;
      endcase
    end
  end

  assign flush = branchTaken && exStage.valid && exStage.cls == CL_BEQ;
  assign stall = needWait && !flush;

  assign strobe.holdFront = stall;
  assign strobe.bubbleEx  = stall || flush;
  assign strobe.squash    = flush;

  // R10: a load into register 0 in execute never holds a non-branch
  a_r10_zero_dst: assert property (@(posedge clk) disable iff (!rst_n)
    (exStage.valid && exStage.cls == CL_LOAD && exStage.regA == '0 && idStage.cls != CL_BEQ) |-> !stall);
  // R4: a stall always has an occupant in decode
  a_r4_stall_has_owner: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> idStage.valid);
endmodule

// File: rtl/pipe_regs.sv
module pipe_regs
  import pipe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strobe,
  input  stage_t            fetched,
  output logic [PC_W-1:0]   fetchPc,
  output stage_t            idStage,
  output stage_t            exStage,
  output stage_t            memStage,
  output stage_t            wbStage,
  output logic [CW_EX-1:0]  exCtrl,
  output logic [CW_MEM-1:0] memCtrl,
  output logic [CW_WB-1:0]  wbCtrl
);
  localparam int EXT_W = PC_W - OFF_W;

  logic [PC_W-1:0] branchTarget;
  assign branchTarget = exStage.pc + {{EXT_W{exStage.offset[OFF_W-1]}}, exStage.offset} + PC_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetchPc  <= '0;
      idStage  <= '0;
      exStage  <= '0;
      memStage <= '0;
      wbStage  <= '0;
      exCtrl   <= '0;
      memCtrl  <= '0;
      wbCtrl   <= '0;
    end else begin
      memStage <= exStage;
      wbStage  <= memStage;
      memCtrl  <= exCtrl[CW_MEM-1:0];
      wbCtrl   <= memCtrl[CW_WB-1:0];
      if (strobe.squash) begin
        fetchPc <= branchTarget;
        idStage <= '0;
      end else if (!strobe.holdFront) begin
        fetchPc <= fetchPc + PC_W'(1);
        idStage <= fetched;
      end
      if (strobe.bubbleEx) begin
        exStage <= '0;
        exCtrl  <= '0;
      end else begin
        exStage <= idStage;
        exCtrl  <= idStage.valid ? ctrlWord(idStage.cls, idStage.regA) : '0;
      end
    end
  end

  // R5: a held front end keeps the fetch index
  a_r5_hold_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.holdFront && !strobe.squash) |=> fetchPc == $past(fetchPc));
  // R5: a bubble request empties execute
  a_r5_bubble_ex: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.bubbleEx |=> !exStage.valid);
  // R8: a squash leaves decode and execute empty
  a_r8_squash: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.squash |=> (!idStage.valid && !exStage.valid));
  // R6: a load in execute reads memory only
  a_r6_load_word: assert property (@(posedge clk) disable iff (!rst_n)
    (exStage.valid && exStage.cls == CL_LOAD) |-> exCtrl[4:2] == 3'b010);
  // R7: a store in memory still carries its write strobe
  a_r7_store_tail: assert property (@(posedge clk) disable iff (!rst_n)
    (memStage.valid && memStage.cls == CL_STORE) |-> memCtrl[4:2] == 3'b001);
endmodule

// File: rtl/loaduse_ctrl.sv
module loaduse_ctrl
  import pipe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetchValid,
  input  logic [1:0]        fetchClass,
  input  logic [REG_W-1:0]  fetchRegA,
  input  logic [REG_W-1:0]  fetchRegB,
  input  logic [REG_W-1:0]  fetchRegC,
  input  logic [OFF_W-1:0]  fetchOffset,
  input  logic              branchTaken,
  output logic [PC_W-1:0]   fetchPc,
  output logic              stall,
  output logic              flush,
  output logic              idValid,
  output logic [1:0]        idClass,
  output logic              exValid,
  output logic [1:0]        exClass,
  output logic              memValid,
  output logic [1:0]        memClass,
  output logic              wbValid,
  output logic [1:0]        wbClass,
  output logic [CW_EX-1:0]  exCtrl,
  output logic [CW_MEM-1:0] memCtrl,
  output logic [CW_WB-1:0]  wbCtrl
);
  stage_t  fetched, idStage, exStage, memStage, wbStage;
  strobe_t strobe;
  logic    unusedFields;

  assign fetched.valid  = fetchValid;
  assign fetched.cls    = instClass_t'(fetchClass);
  assign fetched.regA   = fetchRegA;
  assign fetched.regB   = fetchRegB;
  assign fetched.regC   = fetchRegC;
  assign fetched.offset = fetchOffset;
  assign fetched.pc     = fetchPc;

  hazard_ctrl u_ctrl (
    .idStage(idStage), .exStage(exStage), .memStage(memStage),
    .branchTaken(branchTaken), .clk(clk), .rst_n(rst_n),
    .strobe(strobe), .stall(stall), .flush(flush)
  );

  pipe_regs u_regs (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .fetched(fetched),
    .fetchPc(fetchPc), .idStage(idStage), .exStage(exStage),
    .memStage(memStage), .wbStage(wbStage),
    .exCtrl(exCtrl), .memCtrl(memCtrl), .wbCtrl(wbCtrl)
  );

  assign idValid  = idStage.valid;
  assign idClass  = idStage.cls;
  assign exValid  = exStage.valid;
  assign exClass  = exStage.cls;
  assign memValid = memStage.valid;
  assign memClass = memStage.cls;
  assign wbValid  = wbStage.valid;
  assign wbClass  = wbStage.cls;
  assign unusedFields = ^{idStage, exStage, memStage, wbStage};
endmodule

// File: tb/sim_loaduse_ctrl.sv
`timescale 1ns/1ps
module sim_loaduse_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int errors = 0;
  int checks = 0;

  logic [1:0] pCls [32];
  logic [4:0] pA [32];
  logic [4:0] pB [32];
  logic [4:0] pC [32];
  logic [5:0] pOff [32];
  logic       pTaken [32];
  int         pLen = 0;

  typedef struct packed {
    logic v; logic [1:0] cls; logic [4:0] a; logic [4:0] b; logic [4:0] c;
    logic [5:0] off; logic [7:0] pc;
  } mst_t;
  mst_t mId, mEx, mMem, mWb;
  logic [7:0] mPc;

  logic tStall [64];
  logic tFlush [64];
  logic [7:0] tPc [64];
  logic tIdV [64];
  logic tExV [64];
  logic [6:0] tEx [64];
  logic [4:0] tMem [64];
  logic [1:0] tWb [64];
  int stallCnt;
  int totalCycles;

  logic fetchValid, branchTaken, stall, flush;
  logic [1:0] fetchClass;
  logic [4:0] fetchRegA, fetchRegB, fetchRegC;
  logic [5:0] fetchOffset;
  logic [7:0] fetchPc;
  logic idValid, exValid, memValid, wbValid;
  logic [1:0] idClass, exClass, memClass, wbClass;
  logic [6:0] exCtrl;
  logic [4:0] memCtrl;
  logic [1:0] wbCtrl;

  assign fetchValid  = int'(fetchPc) < pLen;
  assign fetchClass  = pCls[fetchPc[4:0]];
  assign fetchRegA   = pA[fetchPc[4:0]];
  assign fetchRegB   = pB[fetchPc[4:0]];
  assign fetchRegC   = pC[fetchPc[4:0]];
  assign fetchOffset = pOff[fetchPc[4:0]];
  assign branchTaken = mEx.v && mEx.cls == 2'd3 && pTaken[mEx.pc[4:0]];

  loaduse_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .fetchValid(fetchValid), .fetchClass(fetchClass),
    .fetchRegA(fetchRegA), .fetchRegB(fetchRegB), .fetchRegC(fetchRegC),
    .fetchOffset(fetchOffset), .branchTaken(branchTaken), .fetchPc(fetchPc),
    .stall(stall), .flush(flush), .idValid(idValid), .idClass(idClass),
    .exValid(exValid), .exClass(exClass), .memValid(memValid), .memClass(memClass),
    .wbValid(wbValid), .wbClass(wbClass), .exCtrl(exCtrl), .memCtrl(memCtrl), .wbCtrl(wbCtrl)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R6 table written from the requirement
  function automatic logic [6:0] expWord(mst_t s);
    logic [6:0] w;
    if (!s.v) return 7'd0;
    case (s.cls)
      2'd0: w = 7'b0101011;
      2'd1: w = 7'b0100100;
      2'd2: w = 7'b1000010;
      default: w = 7'b0010000;
    endcase
    if ((s.cls == 2'd0 || s.cls == 2'd2) && s.a == 5'd0) w[1] = 1'b0;
    return w;
  endfunction

  function automatic logic ldHit(mst_t s, logic [4:0] r);
    return s.v && s.cls == 2'd0 && s.a != 5'd0 && s.a == r;
  endfunction

  function automatic logic [2:0] occ(logic v, logic [1:0] c);
    return {v, v ? c : 2'd0};
  endfunction

  task automatic stepCycle(int k);
    logic fl, st;
    mst_t f, oldId, oldEx;
    fl = mEx.v && mEx.cls == 2'd3 && pTaken[mEx.pc[4:0]];
    st = 1'b0;
    if (mId.v) begin
      case (mId.cls)
        2'd2: st = ldHit(mEx, mId.b) || ldHit(mEx, mId.c);
        2'd1: st = ldHit(mEx, mId.a);
        2'd3: st = ldHit(mEx, mId.a) || ldHit(mEx, mId.b) || ldHit(mMem, mId.a) || ldHit(mMem, mId.b);
        default: st = 1'b0;
      endcase
    end
    st = st && !fl;
    check("R5 occupancy", {occ(idValid, idClass), occ(exValid, exClass), occ(memValid, memClass),
          occ(wbValid, wbClass), fetchPc},
          {occ(mId.v, mId.cls), occ(mEx.v, mEx.cls), occ(mMem.v, mMem.cls), occ(mWb.v, mWb.cls), mPc});
    check("R9 stall/flush", {stall, flush}, {st, fl});
    check("R6 execute word", exCtrl, expWord(mEx));
    begin
      logic [6:0] wm, ww;
      wm = expWord(mMem);
      ww = expWord(mWb);
      check("R7 tail words", {memCtrl, wbCtrl}, {wm[4:0], ww[1:0]});
    end
    tStall[k] = stall; tFlush[k] = flush; tPc[k] = fetchPc;
    tIdV[k] = idValid; tExV[k] = exValid;
    tEx[k] = exCtrl; tMem[k] = memCtrl; tWb[k] = wbCtrl;
    if (stall) stallCnt++;
    f = '0;
    if (int'(mPc) < pLen) begin
      f.v = 1'b1; f.cls = pCls[mPc[4:0]]; f.a = pA[mPc[4:0]]; f.b = pB[mPc[4:0]];
      f.c = pC[mPc[4:0]]; f.off = pOff[mPc[4:0]]; f.pc = mPc;
    end
    oldId = mId; oldEx = mEx;
    @(posedge clk);
    #1;
    mWb = mMem;
    mMem = oldEx;
    if (fl) begin
      mEx = '0; mId = '0;
      mPc = oldEx.pc + {{2{oldEx.off[5]}}, oldEx.off} + 8'd1;
    end else if (st) begin
      mEx = '0;
    end else begin
      mEx = oldId; mId = f; mPc = mPc + 8'd1;
    end
    @(negedge clk);
  endtask

  task automatic clearProg();
    for (int i = 0; i < 32; i++) begin
      pCls[i] = 2'd0; pA[i] = 5'd0; pB[i] = 5'd0; pC[i] = 5'd0; pOff[i] = 6'd0; pTaken[i] = 1'b0;
    end
  endtask

  task automatic put(int i, logic [1:0] c, logic [4:0] a, logic [4:0] b, logic [4:0] cc,
                     logic [5:0] off, logic tk);
    pCls[i] = c; pA[i] = a; pB[i] = b; pC[i] = cc; pOff[i] = off; pTaken[i] = tk;
  endtask

  task automatic runProg(int n);
    pLen = n;
    rst_n = 1'b0;
    mId = '0; mEx = '0; mMem = '0; mWb = '0; mPc = 8'd0;
    stallCnt = 0; totalCycles = -1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 60; k++) begin
      if (int'(mPc) >= n && !mId.v && !mEx.v && !mMem.v && !mWb.v) begin
        totalCycles = k;
        break;
      end
      stepCycle(k);
    end
  endtask

  // R2 and R1, R7: add after a load stalls once
  task automatic testAluStall();
    clearProg();
    put(0, 2'd0, 5'd5, 5'd1, 5'd0, 6'd0, 1'b0);
    put(1, 2'd2, 5'd6, 5'd5, 5'd1, 6'd0, 1'b0);
    runProg(2);
    check("R1 reset state", {tPc[0], tIdV[0], tExV[0], tStall[0], tFlush[0], tEx[0], tMem[0], tWb[0]}, 32'd0);
    check("R2 stall behind load", {tStall[2], tStall[3]}, 2'b10);
    check("R5 pc held, ex bubble", {tPc[3], tExV[3], tIdV[3]}, {8'd2, 1'b0, 1'b1});
    check("R7 load tails", {tMem[3], tWb[4]}, {5'b01011, 2'b11});
    check("R2 stall count", stallCnt, 1);
    check("R5 total cycles", totalCycles, 7);
  endtask

  // R3: only the data register of a store is compared
  task automatic testStore();
    clearProg();
    put(0, 2'd0, 5'd5, 5'd1, 5'd0, 6'd0, 1'b0);
    put(1, 2'd1, 5'd7, 5'd5, 5'd0, 6'd0, 1'b0);
    put(2, 2'd0, 5'd5, 5'd1, 5'd0, 6'd0, 1'b0);
    put(3, 2'd1, 5'd5, 5'd2, 5'd0, 6'd0, 1'b0);
    runProg(4);
    check("R3 base match ignored", tStall[2], 1'b0);
    check("R3 data match stalls", tStall[4], 1'b1);
    check("R3 stall count", stallCnt, 1);
    check("R3 total cycles", totalCycles, 9);
  endtask

  // R4: branch stalls on loads in execute and memory
  task automatic testBranchWait();
    clearProg();
    put(0, 2'd0, 5'd5, 5'd1, 5'd0, 6'd0, 1'b0);
    put(1, 2'd3, 5'd5, 5'd1, 5'd0, 6'd0, 1'b0);
    put(2, 2'd0, 5'd6, 5'd1, 5'd0, 6'd0, 1'b0);
    put(3, 2'd2, 5'd8, 5'd2, 5'd3, 6'd0, 1'b0);
    put(4, 2'd3, 5'd1, 5'd6, 5'd0, 6'd0, 1'b0);
    runProg(5);
    check("R4 two-cycle wait", {tStall[2], tStall[3], tStall[4]}, 3'b110);
    check("R4 wait on memory-stage load", tStall[7], 1'b1);
    check("R4 stall count", stallCnt, 3);
    check("R4 total cycles", totalCycles, 12);
  endtask

  // R10 and R11: register 0 and forwarded cases never stall
  task automatic testNoStall();
    clearProg();
    put(0, 2'd0, 5'd0, 5'd1, 5'd0, 6'd0, 1'b0);
    put(1, 2'd2, 5'd1, 5'd0, 5'd0, 6'd0, 1'b0);
    put(2, 2'd0, 5'd5, 5'd1, 5'd0, 6'd0, 1'b0);
    put(3, 2'd2, 5'd9, 5'd1, 5'd2, 6'd0, 1'b0);
    put(4, 2'd2, 5'd4, 5'd5, 5'd5, 6'd0, 1'b0);
    put(5, 2'd0, 5'd3, 5'd1, 5'd0, 6'd0, 1'b0);
    put(6, 2'd0, 5'd4, 5'd3, 5'd0, 6'd0, 1'b0);
    runProg(7);
    check("R10 load to r0 word", tEx[2], 7'b0101001);
    check("R10 r0 no stall", tStall[2], 1'b0);
    check("R11 stall count", stallCnt, 0);
    check("R11 total cycles", totalCycles, 11);
  endtask

  // R8: taken branch redirects
  task automatic testTaken();
    clearProg();
    put(0, 2'd2, 5'd1, 5'd2, 5'd3, 6'd0, 1'b0);
    put(1, 2'd3, 5'd1, 5'd2, 5'd0, 6'd2, 1'b1);
    put(2, 2'd2, 5'd7, 5'd1, 5'd1, 6'd0, 1'b0);
    put(3, 2'd2, 5'd8, 5'd1, 5'd1, 6'd0, 1'b0);
    put(4, 2'd2, 5'd9, 5'd1, 5'd1, 6'd0, 1'b0);
    runProg(5);
    check("R8 flush raised", tFlush[3], 1'b1);
    check("R8 redirect and squash", {tPc[4], tIdV[4], tExV[4]}, {8'd4, 1'b0, 1'b0});
    check("R6 branch word", {tEx[3], tMem[4], tWb[5]}, {7'b0010000, 5'b10000, 2'b00});
  endtask

  // R9: flush wins over a stall in the same cycle
  task automatic testCollision();
    clearProg();
    put(0, 2'd0, 5'd5, 5'd1, 5'd0, 6'd0, 1'b0);
    put(1, 2'd3, 5'd1, 5'd1, 5'd0, 6'd3, 1'b1);
    put(2, 2'd3, 5'd5, 5'd2, 5'd0, 6'd0, 1'b0);
    put(5, 2'd2, 5'd9, 5'd1, 5'd1, 6'd0, 1'b0);
    runProg(6);
    check("R9 flush over stall", {tFlush[3], tStall[3]}, 2'b10);
    check("R9 redirect not hold", tPc[4], 8'd5);
  endtask

  initial begin
    testAluStall();
    testStore();
    testBranchWait();
    testNoStall();
    testTaken();
    testCollision();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule